// File: doc/BRIEF.md
# Camera RGB Byte Stream Unpacker

This block sits between an image sensor's 8-bit parallel output and a system-side pixel consumer. Bytes arrive on the sensor's pixel clock. Every byte has its bit order reversed, so the least significant bit of a colour component appears on data line 7. The block rebuilds whole pixels from one of two stream formats. In the 24-bit format, three bytes make one pixel and pixels are packed with no gaps. In the 16-bit format, two bytes make one pixel, and that pixel is reduced to a 15-bit word for a 16-bit display path.

Each finished pixel is written into a small asynchronous FIFO. The pixel leaves in the system clock domain on a valid/ready interface. The system clock is assumed to be faster than the pixel clock. A frame sync pulse latches the stream format and realigns the byte counter. The line-valid input gates which bytes are taken in. A sticky flag in the system domain records any pixel that was lost because the FIFO was full.

Top module: `cam_pix_unpack`

## Requirements
- R1: In 24-bit mode (format input `fmt_565` = 0 at frame sync), three accepted bytes b0, b1, b2 form one pixel. Each component bit k is taken from byte bit 7-k. The output has `out_wide` = 1 and `out_data` = {red from b0, green from b1, blue from b2}, with red in bits 23:16.
- R2: 24-bit pixels are packed back to back. The byte that follows a pixel's blue byte is the red byte of the next pixel, with no padding byte between them.
- R3: In 16-bit mode (`fmt_565` = 1 at frame sync), the first byte carries green bits 3, 4, 5 on lines 7, 6, 5 and red bits 0..4 on lines 4..0. The second byte carries blue bits 0..4 on lines 7..3 and green bits 0, 1, 2 on lines 2, 1, 0. The output has `out_wide` = 0 and `out_data` = {8'h00, 1'b0, R[4:0], G[5:1], B[4:0]}, so green bit 0 is dropped.
- R4: The format is latched only in cycles where `vsync` is high. A change on `fmt_565` in the middle of a frame has no effect until the next frame sync.
- R5: A cycle with `vsync` high discards any partly built pixel, even when line-valid is high. The next accepted byte is then treated as the first byte of a pixel.
- R6: Bytes are taken in only while `lval` is high and `vsync` is low. When `lval` goes low, any partly built pixel is discarded.
- R7: Pixels leave in the order they were completed. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R8: The crossing FIFO holds 8 pixels. A pixel completed while the FIFO is full is dropped, and this sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed in the system domain.
- R9: After reset, `out_valid` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock |
| prst_n | input | 1 | Active-low asynchronous reset, pixel domain |
| vsync | input | 1 | Frame sync; latches format and clears byte phase |
| lval | input | 1 | Line valid; a byte is taken on each pclk edge while high |
| pdata | input | 8 | Sensor byte, bit-reversed per component |
| fmt_565 | input | 1 | Stream format: 1 = 16-bit 5:6:5, 0 = 24-bit 8:8:8 |
| sclk | input | 1 | System clock, faster than pclk |
| srst_n | input | 1 | Active-low asynchronous reset, system domain |
| out_valid | output | 1 | A pixel is presented |
| out_ready | input | 1 | Consumer accepts the presented pixel |
| out_wide | output | 1 | 1 = 24-bit pixel, 0 = 15-bit reduced pixel |
| out_data | output | 24 | Pixel value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky: a pixel was dropped at a full FIFO |

## Verification
The bench aims at the byte-phase corner cases.

- A pixel cut short by line-valid falling, or by a frame sync arriving while line-valid is still high, must produce no output. A design that kept the stale phase would instead produce shifted or mixed pixels from that point on.
- A format change in the middle of a frame must not take effect. A design that sampled the format on every cycle would switch to two-byte pixels partway through the frame.
- The exact bit placement of the 16-bit layout is checked, including the green bit that is dropped. A swapped or off-by-one field shows up as wrong colour values.
- With the consumer stalled, ten pixels are pushed into the eight-entry FIFO. The bench then checks that exactly the first eight come out, that the output held steady during the stall, and that the overflow flag stays set until it is cleared.

// File: rtl/cam_unpack_pkg.sv
package cam_unpack_pkg;

    localparam int BYTE_W = 8;
    localparam int PIX_W  = 25;   // wide flag + 24 data bits

    typedef struct packed {
        logic [1:0]       phase;
        logic             mode565;
        logic [15:0]      acc;
        logic             push;
        logic [PIX_W-1:0] pix;
    } asm_state_t;

    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/cam_sync_bus.sv
module cam_sync_bus #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[0] <= '0;
                else        st_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_q[g-1];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/cam_byte_asm.sv
module cam_byte_asm
    import cam_unpack_pkg::*;
(
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              vsync,
    input  logic              lval,
    input  logic [BYTE_W-1:0] pdata,
    input  logic              fmt_565,
    output logic              push,
    output logic [PIX_W-1:0]  pix
);
    asm_state_t st_d, st_q;
    logic [BYTE_W-1:0] r;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        r         = rev8(pdata);
        if (vsync) begin
            st_d.phase   = 2'd0;
            st_d.mode565 = fmt_565;
        end else if (!lval) begin
            st_d.phase = 2'd0;
        end else if (st_q.mode565) begin
            if (st_q.phase == 2'd0) begin
                st_d.acc[15:8] = r;
                st_d.phase     = 2'd1;
            end else begin
                st_d.push  = 1'b1;
                st_d.pix   = {1'b0, 8'h00, 1'b0, st_q.acc[15:11],
                              st_q.acc[10:8], r[7:6], r[4:0]};
                st_d.phase = 2'd0;
            end
        end else begin
            case (st_q.phase)
                2'd0: begin
                    st_d.acc[15:8] = r;
                    st_d.phase     = 2'd1;
                end
                2'd1: begin
                    st_d.acc[7:0] = r;
                    st_d.phase    = 2'd2;
                end
                default: begin
                    st_d.push  = 1'b1;
                    st_d.pix   = {1'b1, st_q.acc, r};
                    st_d.phase = 2'd0;
                end
            endcase
        end
    end

    always_ff @(posedge pclk or negedge prst_n) begin
        if (!prst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign push = st_q.push;
    assign pix  = st_q.pix;

    // R2: every pixel needs at least two bytes, so pushes never sit back to back
    a_r2_push_spacing: assert property (@(posedge pclk) disable iff (!prst_n)
        push |=> !push);
    // R3: a reduced pixel keeps the upper nine bits clear
    a_r3_narrow_upper_zero: assert property (@(posedge pclk) disable iff (!prst_n)
        (push && !pix[PIX_W-1]) |-> (pix[23:15] == 9'd0));
    // R6: no pixel completes from a cycle without line-valid
    a_r6_no_push_idle: assert property (@(posedge pclk) disable iff (!prst_n)
        !lval |=> !push);
endmodule

// File: rtl/cam_cdc_fifo.sv
module cam_cdc_fifo #(
    parameter int DW     = 25,
    parameter int DEPTH  = 8,
    parameter int SYNC   = 2
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          ovf_tgl,
    input  logic          rclk,
    input  logic          rrst_n,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          tgl;
    } ptr_t;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [DW-1:0] mem_q [DEPTH];
    ptr_t wq, wd, rq, rd;
    logic [PW-1:0] rgray_w, wgray_r;
    logic full, wr_ok, pop;

    cam_sync_bus #(.W(PW), .STAGES(SYNC)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rq.gray), .q(rgray_w));
    cam_sync_bus #(.W(PW), .STAGES(SYNC)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wq.gray), .q(wgray_r));

    // write side
    assign full  = (wq.gray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign wr_ok = wr_en && !full;

    always_comb begin
        wd      = wq;
        wd.bin  = wq.bin + PW'(wr_ok);
        wd.gray = to_gray(wd.bin);
        wd.tgl  = wq.tgl ^ (wr_en && full);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) wq <= '0;
        else         wq <= wd;
    end

    always_ff @(posedge wclk) begin
        if (wr_ok) mem_q[wq.bin[AW-1:0]] <= wr_data;
    end

    assign ovf_tgl = wq.tgl;

    // read side
    assign rd_valid = (rq.gray != wgray_r);
    assign pop      = rd_valid && rd_ready;
    assign rd_data  = mem_q[rq.bin[AW-1:0]];

    always_comb begin
        rd      = rq;
        rd.bin  = rq.bin + PW'(pop);
        rd.gray = to_gray(rd.bin);
        rd.tgl  = 1'b0;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) rq <= '0;
        else         rq <= rd;
    end

    // R8: a write attempt at a full FIFO does not advance the write pointer
    a_r8_drop_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> $stable(wq.bin));
    // R7: a stalled output holds its pixel
    a_r7_hold_stall: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/cam_ovf_sticky.sv
module cam_ovf_sticky #(
    parameter int SYNC = 2
) (
    input  logic sclk,
    input  logic srst_n,
    input  logic tgl_in,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic last;
        logic flag;
    } ovf_t;

    ovf_t oq, od;
    logic tgl_s, evt;

    cam_sync_bus #(.W(1), .STAGES(SYNC)) u_sync (
        .clk(sclk), .rst_n(srst_n), .d(tgl_in), .q(tgl_s));

    assign evt = tgl_s ^ oq.last;

    always_comb begin
        od      = oq;
        od.last = tgl_s;
        if (evt)      od.flag = 1'b1;
        else if (clr) od.flag = 1'b0;
    end

    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n) oq <= '0;
        else         oq <= od;
    end

    assign flag = oq.flag;

    // R8: the flag stays set until cleared
    a_r8_flag_sticky: assert property (@(posedge sclk) disable iff (!srst_n)
        (flag && !clr) |=> flag);
    // R8: a clear with no new event empties the flag
    a_r8_flag_clear: assert property (@(posedge sclk) disable iff (!srst_n)
        (clr && !evt) |=> !flag);
endmodule

// File: rtl/cam_pix_unpack.sv
module cam_pix_unpack #(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        pclk,
    input  logic        prst_n,
    input  logic        vsync,
    input  logic        lval,
    input  logic [7:0]  pdata,
    input  logic        fmt_565,
    input  logic        sclk,
    input  logic        srst_n,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_wide,
    output logic [23:0] out_data,
    input  logic        ovf_clr,
    output logic        ovf_flag
);
    import cam_unpack_pkg::*;

    logic             push;
    logic [PIX_W-1:0] pix, rd_pix;
    logic             ovf_tgl;

    cam_byte_asm u_asm (
        .pclk(pclk), .prst_n(prst_n), .vsync(vsync), .lval(lval),
        .pdata(pdata), .fmt_565(fmt_565), .push(push), .pix(pix));

    cam_cdc_fifo #(.DW(PIX_W), .DEPTH(FIFO_DEPTH), .SYNC(SYNC_STAGES)) u_fifo (
        .wclk(pclk), .wrst_n(prst_n), .wr_en(push), .wr_data(pix),
        .ovf_tgl(ovf_tgl), .rclk(sclk), .rrst_n(srst_n),
        .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(rd_pix));

    cam_ovf_sticky #(.SYNC(SYNC_STAGES)) u_ovf (
        .sclk(sclk), .srst_n(srst_n), .tgl_in(ovf_tgl),
        .clr(ovf_clr), .flag(ovf_flag));

    assign out_wide = rd_pix[PIX_W-1];
    assign out_data = rd_pix[23:0];
endmodule

// File: tb/tb_cam_pix_unpack.sv
module tb_cam_pix_unpack;
    localparam int CLK_PERIOD  = 7;
    localparam int PCLK_PERIOD = 20;

    logic pclk = 0, sclk = 0, rst_n = 0;
    logic vsync = 0, lval = 0, fmt_565 = 0, out_ready = 0, ovf_clr = 0;
    logic [7:0] pdata = 0;
    logic out_valid, out_wide, ovf_flag;
    logic [23:0] out_data;

    int errors = 0, checks = 0, cycles = 0;
    bit cons_en = 1;
    logic [24:0] exp_q[$];

    always #(PCLK_PERIOD/2) pclk = ~pclk;
    always #(CLK_PERIOD/2.0) sclk = ~sclk;

    cam_pix_unpack dut (
        .pclk(pclk), .prst_n(rst_n), .vsync(vsync), .lval(lval), .pdata(pdata),
        .fmt_565(fmt_565), .sclk(sclk), .srst_n(rst_n), .out_valid(out_valid),
        .out_ready(out_ready), .out_wide(out_wide), .out_data(out_data),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] m888(input logic [7:0] b0, b1, b2);
        logic [7:0] r, g, b;
        for (int k = 0; k < 8; k++) begin
            r[k] = b0[7-k]; g[k] = b1[7-k]; b[k] = b2[7-k];
        end
        return {1'b1, r, g, b};
    endfunction

    function automatic logic [24:0] m565(input logic [7:0] b0, b1);
        logic [4:0] r, b; logic [5:0] g;
        for (int k = 0; k < 5; k++) begin
            r[k] = b0[4-k]; b[k] = b1[7-k];
        end
        g[3] = b0[7]; g[4] = b0[6]; g[5] = b0[5];
        g[0] = b1[2]; g[1] = b1[1]; g[2] = b1[0];
        return {1'b0, 8'h00, 1'b0, r, g[5:1], b};
    endfunction

    task automatic drive(input logic v, input logic l, input logic [7:0] b);
        vsync = v; lval = l; pdata = b;
        @(negedge pclk);
    endtask

    task automatic frame(input logic f, input logic keep_l);
        fmt_565 = f;
        drive(1, keep_l, 8'hA5);
        vsync = 0;
    endtask

    task automatic px888(input logic [7:0] b0, b1, b2, input bit expect_it);
        drive(0, 1, b0); drive(0, 1, b1); drive(0, 1, b2);
        if (expect_it) exp_q.push_back(m888(b0, b1, b2));
    endtask

    task automatic px565(input logic [7:0] b0, b1);
        drive(0, 1, b0); drive(0, 1, b1);
        exp_q.push_back(m565(b0, b1));
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge sclk);
        repeat (10) @(negedge sclk);
        chk(exp_q.size() == 0, "R7 all pixels delivered", exp_q.size(), 0);
    endtask

    // consumer: ready chosen at negedge, handshake completes at the next posedge
    initial begin
        logic [24:0] e;
        forever begin
            @(negedge sclk);
            out_ready = cons_en ? (($urandom % 4) != 0) : 1'b0;
            if (rst_n && out_ready && out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6/R7 unexpected pixel", {out_wide, out_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({out_wide, out_data} == e,
                        e[24] ? "R1/R2/R4/R5 wide pixel" : "R3 reduced pixel",
                        {out_wide, out_data}, e);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge pclk);
            cycles++;
            if (cycles > 150000) begin
                chk(0, "watchdog", cycles, 0);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge pclk);
        chk(out_valid == 0, "R9 reset valid", out_valid, 0);
        chk(ovf_flag == 0, "R9 reset ovf", ovf_flag, 0);
        rst_n = 1;
        @(negedge pclk);

        // R1 directed and R2 back-to-back random 24-bit pixels
        frame(0, 0);
        px888(8'h01, 8'h80, 8'hF0, 1);
        px888(8'hFF, 8'h00, 8'h5A, 1);
        for (int i = 0; i < 20; i++) px888($urandom, $urandom, $urandom, 1);
        drive(0, 0, 0);
        // R4: format input flips mid-frame; pixels stay 24-bit
        fmt_565 = 1;
        for (int i = 0; i < 4; i++) px888($urandom, $urandom, $urandom, 1);
        // R6: line drops after two bytes, partial pixel discarded
        drive(0, 1, 8'h11); drive(0, 1, 8'h22); drive(0, 0, 8'h33);
        px888(8'h3C, 8'hC3, 8'h96, 1);
        drive(0, 0, 0);
        // R6: bytes with lval low are ignored
        drive(0, 0, 8'h77); drive(0, 0, 8'h88);
        px888(8'h12, 8'h34, 8'h56, 1);
        drive(0, 0, 0);
        drain();

        // R3: 16-bit frame, directed then random with line gaps
        frame(1, 0);
        px565(8'hE0, 8'h07);   // only green bits set: G5..G3 and G2..G0
        px565(8'h1F, 8'hF8);   // red all ones, blue all ones
        px565(8'h80, 8'h00);   // only G3
        px565(8'h00, 8'h04);   // only G0, dropped
        for (int i = 0; i < 30; i++) begin
            px565($urandom, $urandom);
            for (int j = 0; j < int'($urandom % 3); j++) drive(0, 0, 0);
        end
        drive(0, 0, 0);
        // R5: sync while line-valid high discards a half pixel
        drive(0, 1, 8'hAA);
        frame(1, 1);
        px565(8'h5A, 8'hC3);
        // R5 + R4: new frame switches to 24-bit after one stray byte
        drive(0, 1, 8'h99);
        frame(0, 1);
        px888(8'h0F, 8'hF0, 8'h33, 1);
        drive(0, 0, 0);
        drain();
        chk(ovf_flag == 0, "R8 no false overflow", ovf_flag, 0);

        // R8 overflow with stalled consumer
        cons_en = 0;
        repeat (5) @(negedge sclk);
        frame(0, 0);
        for (int i = 0; i < 10; i++) px888($urandom, $urandom, $urandom, i < 8);
        drive(0, 0, 0);
        repeat (20) @(negedge pclk);
        chk(ovf_flag == 1, "R8 overflow set", ovf_flag, 1);
        @(negedge sclk);
        held = out_data;
        repeat (6) @(negedge sclk);
        chk(out_valid == 1, "R7 valid held in stall", out_valid, 1);
        chk(out_data == held, "R7 data held in stall", out_data, held);
        chk(ovf_flag == 1, "R8 flag sticky", ovf_flag, 1);
        cons_en = 1;
        drain();
        chk(ovf_flag == 1, "R8 flag sticky after drain", ovf_flag, 1);
        @(negedge sclk); ovf_clr = 1;
        @(negedge sclk); ovf_clr = 0;
        @(negedge sclk);
        chk(ovf_flag == 0, "R8 flag cleared", ovf_flag, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule